// File: doc/BRIEF.md
# Mesh Graph Bisection Engine

The engine splits a two-dimensional mesh graph into two halves. Each node is a cell of a ROWS by COLS array, and each cell holds a one-bit side label. The search tries to keep the halves equal in size while cutting as few mesh edges as possible. Every cell has its own pseudo-random source, seeded from a common seed value. The sources give each cell a random first label, and on every trial they flip the cells whose random draw falls below a temperature threshold. A shared scoring network adds up the cut edges and the size imbalance of each trial labelling. A trial that scores no worse than the current labelling is accepted. A trial that scores worse is discarded, so the array reverts to the current labelling. A separate copy keeps the best labelling seen, and it is overwritten only on a strict improvement.

Software or a host sequencer sets the seed, the temperature and the trial budget, and pulses start. It then waits for done and reads the best cost and the best label vector. These stay frozen until the next start. A run with temperature zero never flips anything, so the returned labelling is the random starting point. A high temperature lets many cells move on each trial.

Top module: `mesh_bisector`

## Requirements
- R1: After reset, done is 0, best_cost is 0 and best_labels is all zeros.
- R2: When done is 1, best_cost equals the cut count plus the imbalance of best_labels. Node (r,c) is bit r*COLS+c. The cut count is the number of right (c,c+1) and down (r,r+1) neighbour pairs whose labels differ. The imbalance is the absolute difference between the number of 1 labels and the number of 0 labels.
- R3: A run starts when start is 1 at a rising edge while the engine is idle or done. For a trial budget L, done rises after exactly 2L+3 rising edges, counting the edge that sampled start. done is 0 while a run is in progress.
- R4: Two runs with the same seed, temperature and trial budget return identical best_labels and best_cost.
- R5: With temperature 0 no cell ever flips, so the result equals that of a zero-trial run with the same seed.
- R6: The best cost never increases during a run and never exceeds the current accepted cost. For the same seed and temperature, a larger trial budget never gives a higher best_cost, and no run beats a zero-trial run by giving a higher best_cost.
- R7: Once done is 1, done, best_cost and best_labels stay unchanged until the next accepted start.
- R8: start pulses while a run is in progress are ignored. The run's timing and result are unchanged.
- R9: Temperature and trial budget are captured at the accepted start. Changes to them during a run have no effect on its timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new search when idle or done |
| seed | input | 16 | Seed for all per-cell random sources |
| temperature | input | 16 | Flip threshold: a cell flips when its 16-bit draw is below this value |
| iter_limit | input | ITER_W | Number of perturbation trials in a run |
| done | output | 1 | High once the run is complete, held until the next start |
| best_cost | output | CW | Lowest cost found, CW = clog2(edges + nodes + 1) |
| best_labels | output | ROWS*COLS | Best labelling, one bit per node |

## Verification
The in-RTL properties assume nothing about start: it may arrive at any cycle, including while a run is busy. The hold and monotonic-cost properties are therefore guarded only by start and state. The zero-temperature property relies on the temperature copy captured at start, not on the live input. This leaves the bench free to move the temperature pins in mid-run. The stimulus uses random seeds, temperatures and budgets of at least 3 trials, so a disturbance injected in the fifth cycle always falls inside a busy run. Directed cases add a zero budget, zero temperature, repeated seeds and nested budgets.

// File: rtl/bis_pkg.sv
package bis_pkg;

  localparam int RAND_W = 16;
  localparam logic [RAND_W-1:0] RAND_TAPS = 16'hB400;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_JUDGE = 3'd2,
    ST_PERT  = 3'd3,
    ST_DONE  = 3'd4
  } bis_state_e;

  function automatic logic [RAND_W-1:0] rand_step(input logic [RAND_W-1:0] s);
    rand_step = s[0] ? ((s >> 1) ^ RAND_TAPS) : (s >> 1);
  endfunction

endpackage

// File: rtl/bis_rst_sync.sv
module bis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];

endmodule

// File: rtl/bis_cell.sv
module bis_cell
  import bis_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_ld,
  input  logic [RAND_W-1:0] seed,
  input  logic              init_ld,
  input  logic              pert,
  input  logic              accept,
  input  logic              keep,
  input  logic [RAND_W-1:0] temp,
  output logic              trial_o,
  output logic              best_o
);

  localparam logic [RAND_W-1:0] SALT = RAND_W'((IDX + 1) * 40503);

  logic [RAND_W-1:0] lfsr_q, lfsr_d, mix;
  logic              cur_q, cur_d;
  logic              trial_q, trial_d;
  logic              best_q, best_d;
  logic              flip;

  assign mix  = seed ^ SALT;
  assign flip = (lfsr_q < temp);

  always_comb begin
    lfsr_d  = lfsr_q;
    trial_d = trial_q;
    cur_d   = cur_q;
    best_d  = best_q;
    if (seed_ld)              lfsr_d = (mix == '0) ? RAND_W'(1) : mix;
    else if (init_ld || pert) lfsr_d = rand_step(lfsr_q);
    if (init_ld)   trial_d = lfsr_q[0];
    else if (pert) trial_d = cur_q ^ flip;
    if (accept) cur_d  = trial_q;
    if (keep)   best_d = trial_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= RAND_W'(1);
      cur_q   <= 1'b0;
      trial_q <= 1'b0;
      best_q  <= 1'b0;
    end else begin
      lfsr_q  <= lfsr_d;
      cur_q   <= cur_d;
      trial_q <= trial_d;
      best_q  <= best_d;
    end
  end

  assign trial_o = trial_q;
  assign best_o  = best_q;

  AST_COLD_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pert && temp == '0) |=> (trial_q == cur_q)); // R5

endmodule

// File: rtl/bis_cost.sv
module bis_cost #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int CW   = 8
) (
  input  logic [ROWS*COLS-1:0] lbl,
  output logic [CW-1:0]        cost
);

  localparam int N = ROWS * COLS;

  logic [CW-1:0] cuts;
  logic [CW-1:0] ones;
  logic [CW:0]   twice;
  logic [CW:0]   imb;

  always_comb begin
    cuts = '0;
    ones = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        ones = ones + CW'(lbl[r*COLS+c]);
        if (c < COLS - 1) cuts = cuts + CW'(lbl[r*COLS+c] ^ lbl[r*COLS+c+1]);
        if (r < ROWS - 1) cuts = cuts + CW'(lbl[r*COLS+c] ^ lbl[(r+1)*COLS+c]);
      end
    end
    twice = {ones, 1'b0};
    imb   = (twice >= (CW+1)'(N)) ? (twice - (CW+1)'(N)) : ((CW+1)'(N) - twice);
    cost  = cuts + CW'(imb);
  end

endmodule

// File: rtl/mesh_bisector.sv
module mesh_bisector
  import bis_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int ITER_W = 16,
  localparam int N     = ROWS * COLS,
  localparam int EDGES = ROWS * (COLS - 1) + (ROWS - 1) * COLS,
  localparam int CW    = $clog2(EDGES + N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       seed,
  input  logic [15:0]       temperature,
  input  logic [ITER_W-1:0] iter_limit,
  output logic              done,
  output logic [CW-1:0]     best_cost,
  output logic [N-1:0]      best_labels
);

  logic rst_n_s;

  bis_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  bis_state_e        state_q, state_d;
  logic              first_q, first_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic [ITER_W-1:0] lim_q, lim_d;
  logic [RAND_W-1:0] temp_q, temp_d;
  logic [CW-1:0]     cur_cost_q, cur_cost_d;
  logic [CW-1:0]     best_cost_q, best_cost_d;

  logic [N-1:0] trial_v;
  logic [N-1:0] best_v;
  logic [CW-1:0] tcost;
  logic start_ok, judge, acc, kp, init_ld, pert;

  assign start_ok = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign judge    = (state_q == ST_JUDGE);
  assign acc      = judge && (first_q || tcost <= cur_cost_q);
  assign kp       = judge && (first_q || tcost < best_cost_q);
  assign init_ld  = (state_q == ST_INIT);
  assign pert     = (state_q == ST_PERT);

  for (genvar i = 0; i < N; i++) begin : g_cell
    bis_cell #(.IDX(i)) i_cell (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .seed_ld (start_ok),
      .seed    (seed),
      .init_ld (init_ld),
      .pert    (pert),
      .accept  (acc),
      .keep    (kp),
      .temp    (temp_q),
      .trial_o (trial_v[i]),
      .best_o  (best_v[i])
    );
  end

  bis_cost #(.ROWS(ROWS), .COLS(COLS), .CW(CW)) i_cost (
    .lbl  (trial_v),
    .cost (tcost)
  );

  always_comb begin
    state_d     = state_q;
    first_d     = first_q;
    iter_d      = iter_q;
    lim_d       = lim_q;
    temp_d      = temp_q;
    cur_cost_d  = cur_cost_q;
    best_cost_d = best_cost_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_INIT;
          lim_d   = iter_limit;
          temp_d  = temperature;
          iter_d  = '0;
          first_d = 1'b1;
        end
      end
      ST_INIT: state_d = ST_JUDGE;
      ST_JUDGE: begin
        first_d = 1'b0;
        if (acc) cur_cost_d  = tcost;
        if (kp)  best_cost_d = tcost;
        state_d = (iter_q == lim_q) ? ST_DONE : ST_PERT;
      end
      ST_PERT: begin
        iter_d  = iter_q + 1'b1;
        state_d = ST_JUDGE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q     <= ST_IDLE;
      first_q     <= 1'b0;
      iter_q      <= '0;
      lim_q       <= '0;
      temp_q      <= '0;
      cur_cost_q  <= '0;
      best_cost_q <= '0;
    end else begin
      state_q     <= state_d;
      first_q     <= first_d;
      iter_q      <= iter_d;
      lim_q       <= lim_d;
      temp_q      <= temp_d;
      cur_cost_q  <= cur_cost_d;
      best_cost_q <= best_cost_d;
    end
  end

  assign done        = (state_q == ST_DONE);
  assign best_cost   = best_cost_q;
  assign best_labels = best_v;

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !start) |=> done); // R7
  AST_BEST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !start) |=> ($stable(best_labels) && $stable(best_cost))); // R7
  AST_BEST_NOT_WORSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (judge && !first_q) |=> (best_cost_q <= $past(best_cost_q))); // R6
  AST_CUR_NOT_WORSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (judge && !first_q) |=> (cur_cost_q <= $past(cur_cost_q))); // R6
  AST_BEST_LE_CUR: assert property (@(posedge clk) disable iff (!rst_n_s)
    pert |-> (best_cost_q <= cur_cost_q)); // R6
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE && state_q != ST_DONE) |-> !done); // R3
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && pert) |=> (state_q == ST_JUDGE)); // R8

endmodule

// File: tb/test_mesh_bisector.sv
`timescale 1ns/1ps
module test_mesh_bisector;

  localparam int ROWS   = 8;
  localparam int COLS   = 8;
  localparam int ITER_W = 16;
  localparam int N      = ROWS * COLS;
  localparam int EDGES  = ROWS * (COLS - 1) + (ROWS - 1) * COLS;
  localparam int CW     = $clog2(EDGES + N + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [15:0]       seed;
  logic [15:0]       temperature;
  logic [ITER_W-1:0] iter_limit;
  logic              done;
  logic [CW-1:0]     best_cost;
  logic [N-1:0]      best_labels;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mesh_bisector #(.ROWS(ROWS), .COLS(COLS), .ITER_W(ITER_W)) i_mesh_bisector (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .temperature(temperature), .iter_limit(iter_limit),
    .done(done), .best_cost(best_cost), .best_labels(best_labels)
  );

  function automatic int cost_of(input logic [N-1:0] v);
    int cut = 0;
    int ones = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        ones += int'(v[r*COLS+c]);
        if (c < COLS - 1 && v[r*COLS+c] != v[r*COLS+c+1]) cut++;
        if (r < ROWS - 1 && v[r*COLS+c] != v[(r+1)*COLS+c]) cut++;
      end
    return cut + ((2*ones > N) ? (2*ones - N) : (N - 2*ones));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: clean, 1: extra start in mid-run, 2: move temperature/limit in mid-run
  task automatic run(input logic [15:0] sd, input logic [15:0] tp, input int lim, input int mode,
                     output int cyc, output logic [N-1:0] lab, output int cst);
    @(negedge clk);
    seed = sd; temperature = tp; iter_limit = ITER_W'(lim); start = 1'b1;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (done || cyc > 5000) break;
      start = 1'b0;
      if (mode == 1 && cyc == 5) start = 1'b1;
      if (mode == 2 && cyc == 5) begin
        temperature = ~tp;
        iter_limit  = ITER_W'(lim + 7);
      end
    end
    start = 1'b0;
    lab = best_labels;
    cst = int'(best_cost);
  endtask

  initial begin
    int cyc, cst, cst0, cst_b;
    logic [N-1:0] lab, lab0, lab_b;
    logic [15:0] sd, tp;
    int lim;
    void'($urandom(32'd7301));
    rst_n = 1'b0; start = 1'b0; seed = '0; temperature = '0; iter_limit = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done", 128'(done), 0);
    chk(best_cost == '0, "R1 best_cost", 128'(best_cost), 0);
    chk(best_labels == '0, "R1 best_labels", 128'(best_labels), 0);

    // random runs: timing, cost definition, determinism, keep-best
    for (int k = 0; k < 8; k++) begin
      sd  = 16'($urandom);
      tp  = 16'($urandom_range(0, 65535));
      lim = int'($urandom_range(3, 60));
      run(sd, tp, lim, 0, cyc, lab, cst);
      chk(cyc == 2*lim + 3, "R3 done latency", 128'(cyc), 128'(2*lim + 3));
      chk(cst == cost_of(lab), "R2 cost of best labels", 128'(cst), 128'(cost_of(lab)));
      run(sd, tp, lim, 0, cyc, lab_b, cst_b);
      chk(lab_b == lab && cst_b == cst, "R4 repeat run", 128'(lab_b), 128'(lab));
      run(sd, tp, 0, 0, cyc, lab0, cst0);
      chk(cyc == 3, "R3 zero budget latency", 128'(cyc), 3);
      chk(cst0 == cost_of(lab0), "R2 cost of initial labels", 128'(cst0), 128'(cost_of(lab0)));
      chk(cst <= cst0, "R6 best not above start", 128'(cst), 128'(cst0));
    end

    // temperature zero leaves the start labelling in place
    sd = 16'h5A17;
    run(sd, 16'h0000, 0, 0, cyc, lab0, cst0);
    run(sd, 16'h0000, 25, 0, cyc, lab, cst);
    chk(lab == lab0 && cst == cst0, "R5 cold run keeps start", 128'(lab), 128'(lab0));

    // seed 0 and a nested budget
    run(16'h0000, 16'h0800, 10, 0, cyc, lab0, cst0);
    run(16'h0000, 16'h0800, 60, 0, cyc, lab, cst);
    chk(cst <= cst0, "R6 larger budget not worse", 128'(cst), 128'(cst0));
    chk(cst == cost_of(lab), "R2 seed zero cost", 128'(cst), 128'(cost_of(lab)));

    // hold after done
    lab_b = best_labels; cst_b = int'(best_cost);
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R7 done held", 128'(done), 1);
    chk(best_labels == lab_b && int'(best_cost) == cst_b, "R7 outputs frozen", 128'(best_labels), 128'(lab_b));

    // mid-run disturbances
    for (int k = 0; k < 3; k++) begin
      sd  = 16'($urandom);
      tp  = 16'($urandom_range(256, 8192));
      lim = int'($urandom_range(4, 30));
      run(sd, tp, lim, 0, cyc, lab0, cst0);
      run(sd, tp, lim, 1, cyc, lab, cst);
      chk(cyc == 2*lim + 3, "R8 busy start timing", 128'(cyc), 128'(2*lim + 3));
      chk(lab == lab0 && cst == cst0, "R8 busy start result", 128'(lab), 128'(lab0));
      run(sd, tp, lim, 2, cyc, lab, cst);
      chk(cyc == 2*lim + 3, "R9 latched budget", 128'(cyc), 128'(2*lim + 3));
      chk(lab == lab0 && cst == cst0, "R9 latched temperature", 128'(lab), 128'(lab0));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule